// File: doc/BRIEF.md
# Clock-Synchronous Serial Port with Slave-Select

This block moves one byte in each direction per frame over a three-wire synchronous serial link, with an active-low select input. It can act as clock master or as clock slave. As master it divides the system clock down to a serial clock, produces exactly eight clock periods per byte and samples its own data input. As slave it brings an external serial clock and the select line into the system clock domain and shifts on the edges it detects there. In either role the byte goes out least-significant bit first and the receive shift register fills at the same time.

Two inputs set the clock mode. `cpol` gives the level at which the serial clock idles. `cpha` works as a "clock delay" control. With `cpha`=1 the first bit is put on the line before the first clock edge; bits are sampled on leading edges and changed on trailing edges. With `cpha`=0 each bit is launched on a leading edge and sampled on the next trailing edge, so the slave output has no defined value before the first edge. The leading edge is the first transition away from the idle level. Both ends of a link must use the same mode.

The transmit byte enters through a valid/ready handshake. In master mode an accepted byte starts a frame at once. In slave mode it is held until the external master selects the port. A received byte is announced by a one-cycle done strobe.

Top module: `serport`

## Requirements
- R1: After reset, `tx_ready`=1, `rx_done`=0, `rx_data`=0x00, `sck_out` equals `cpol`, and in master mode (`role_slave`=0) `sd_oe`=1.
- R2: In master mode a handshake (`tx_valid`&`tx_ready` at a clock edge) starts a frame. `sck_out` then makes exactly 16 transitions, spaced HALF_DIV system clocks apart, and afterwards rests at the `cpol` level. `tx_ready` is 0 from the cycle after acceptance until the frame ends.
- R3: Bits are sent least-significant first. In master mode, with `sd_out` looped back to `sd_in`, the byte received equals the byte sent in all four combinations of `cpol` and `cpha`. With `sd_in` held at 1 the byte received is 0xFF.
- R4: With `cpha`=1 bit 0 is on `sd_out` before the first clock edge, and data is sampled on leading edges. With `cpha`=0 each bit is launched on a leading edge and sampled on the trailing edge that follows.
- R5: In slave mode (`role_slave`=1), `sd_oe` is 0 whenever `ssel_n` is 1, for either value of `cpha`.
- R6: In slave mode with `cpha`=1, within four system clocks after `ssel_n` falls, `sd_oe`=1 and `sd_out` carries bit 0 of the loaded byte.
- R7: In slave mode the port sends the loaded byte, one bit per launch edge of `sck_in`. It takes `sd_in` on the sampling edges and raises `rx_done` after the eighth sample, in all four clock modes.
- R8: If `ssel_n` rises before eight bits have been sampled, the frame is dropped. No `rx_done` follows, `sd_oe` returns to 0, and the next full frame is received correctly from its first bit.
- R9: `rx_done` is high for exactly one system clock per completed frame. `rx_data` changes only in that cycle and holds its value until the next completion.
- R10: In slave mode a transmit byte that has been loaded holds `tx_ready` at 0 until the frame that uses it ends, whether it completes or is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| role_slave | input | 1 | 0 = master with internal clock, 1 = slave with external clock |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 1 = first bit before first edge (clock delay), 0 = launch on leading edge |
| tx_data | input | DW | Byte to transmit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Port can take a transmit byte |
| rx_data | output | DW | Last byte received |
| rx_done | output | 1 | One-cycle strobe when a byte completes |
| sck_out | output | 1 | Serial clock generated in master mode |
| sck_in | input | 1 | External serial clock used in slave mode |
| sd_in | input | 1 | Serial data input |
| sd_out | output | 1 | Serial data output |
| sd_oe | output | 1 | Output enable for the data pad |
| ssel_n | input | 1 | Active-low select, used in slave mode |

## Verification
If the bit counter is wrong, `rx_done` comes early or late, or the received byte is rotated. Either shows at the ports within the frame where the counter slips. If the launch and sample edges are swapped, wrong bits appear on `sd_out` within one serial clock period, and loopback then returns a shifted byte. If the dropped-frame path does not clear the counter, the next frame gives a misaligned byte. A held-byte flag that fails to clear leaves `tx_ready` low from the end of that frame on.

// File: rtl/serport_pkg.sv
package serport_pkg;
  // One set of shift events, either from the master clock generator or
  // from the slave edge detector.
  typedef struct packed {
    logic start;
    logic lead;
    logic trail;
    logic abort;
  } sp_evt_t;
endpackage

// File: rtl/serport_mclk.sv
module serport_mclk #(
  parameter int HALF_DIV = 4,
  parameter int DW       = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 cpol,
  output logic                 sck,
  output logic                 busy,
  output serport_pkg::sp_evt_t evt
);
  localparam int TICKS = 2 * DW;
  localparam int TW    = $clog2(TICKS);
  localparam int DIVW  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIVW-1:0] DIV_LOAD = DIVW'(HALF_DIV - 1);
  localparam logic [TW-1:0]   LAST     = TW'(TICKS - 1);

  logic            run_q, run_d;
  logic [DIVW-1:0] div_q, div_d;
  logic [TW-1:0]   hc_q, hc_d;
  logic            sck_q, sck_d;
  logic            tick;

  always_comb begin
    tick  = run_q && (div_q == '0);
    run_d = run_q;
    div_d = div_q;
    hc_d  = hc_q;
    sck_d = sck_q;
    if (start && !run_q) begin
      run_d = 1'b1;
      div_d = DIV_LOAD;
      hc_d  = '0;
      sck_d = cpol;
    end else if (run_q) begin
      if (tick) begin
        div_d = DIV_LOAD;
        hc_d  = hc_q + 1'b1;
        sck_d = ~sck_q;
        if (hc_q == LAST) run_d = 1'b0;
      end else begin
        div_d = div_q - 1'b1;
      end
    end else begin
      sck_d = cpol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      div_q <= '0;
      hc_q  <= '0;
      sck_q <= 1'b0;
    end else begin
      run_q <= run_d;
      div_q <= div_d;
      hc_q  <= hc_d;
      sck_q <= sck_d;
    end
  end

  assign sck       = sck_q;
  assign busy      = run_q;
  assign evt.start = start;
  assign evt.lead  = tick && !hc_q[0];
  assign evt.trail = tick && hc_q[0];
  assign evt.abort = 1'b0;

  // R2: an even number of transitions brings the clock back to idle
  assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> (sck_q == cpol));
endmodule

// File: rtl/serport_sync.sv
module serport_sync #(
  parameter int SYNC = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sck_in,
  input  logic                 ssel_n,
  input  logic                 cpol,
  output logic                 sel_low,
  output serport_pkg::sp_evt_t evt
);
  logic [SYNC:0] sck_p;
  logic [SYNC:0] sel_p;
  logic          sck_s, sck_o, sel_s, sel_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= '0;
      sel_p <= '1;
    end else begin
      sck_p <= {sck_p[SYNC-1:0], sck_in};
      sel_p <= {sel_p[SYNC-1:0], ssel_n};
    end
  end

  assign sck_s = sck_p[SYNC-1];
  assign sck_o = sck_p[SYNC];
  assign sel_s = sel_p[SYNC-1];
  assign sel_o = sel_p[SYNC];

  assign sel_low   = !sel_o;
  assign evt.start = sel_o && !sel_s;
  assign evt.abort = !sel_o && sel_s;
  assign evt.lead  = (sck_s != sck_o) && (sck_o == cpol);
  assign evt.trail = (sck_s != sck_o) && (sck_o != cpol);
endmodule

// File: rtl/serport_core.sv
module serport_core #(
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 slave,
  input  logic                 cpha,
  input  serport_pkg::sp_evt_t evt,
  input  logic                 ld,
  input  logic [DW-1:0]        ld_data,
  input  logic                 sd_in,
  output logic                 dbit,
  output logic                 active,
  output logic                 held,
  output logic [DW-1:0]        rx_data,
  output logic                 rx_done
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LASTBIT = CW'(DW - 1);

  logic [DW-1:0] sreg_q, sreg_d, rreg_q, rreg_d, rx_q, rx_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          dbit_q, dbit_d, act_q, act_d, held_q, held_d, done_q, done_d;
  logic [DW-1:0] src, rx_shift;
  logic          launch, sample, complete;

  always_comb begin
    src      = ld ? ld_data : sreg_q;
    rx_shift = {sd_in, rreg_q[DW-1:1]};
    launch   = act_q && (cpha ? evt.trail : evt.lead);
    sample   = act_q && (cpha ? evt.lead : evt.trail);
    complete = 1'b0;
    sreg_d   = sreg_q;
    rreg_d   = rreg_q;
    rx_d     = rx_q;
    cnt_d    = cnt_q;
    dbit_d   = dbit_q;
    act_d    = act_q;
    done_d   = 1'b0;
    if (ld && !act_q) sreg_d = ld_data;
    if (evt.abort) begin
      act_d  = 1'b0;
      cnt_d  = '0;
      sreg_d = '0;
    end else if (evt.start) begin
      act_d = 1'b1;
      cnt_d = '0;
      if (cpha) begin
        dbit_d = src[0];
        sreg_d = src >> 1;
      end else begin
        sreg_d = src;
      end
    end else begin
      if (launch) begin
        dbit_d = sreg_q[0];
        sreg_d = sreg_q >> 1;
      end
      if (sample) begin
        rreg_d = rx_shift;
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == LASTBIT) begin
          complete = 1'b1;
          act_d    = 1'b0;
          cnt_d    = '0;
          rx_d     = rx_shift;
          done_d   = 1'b1;
          sreg_d   = '0;
        end
      end
    end
    if (!slave || evt.abort || complete) held_d = 1'b0;
    else if (ld)                         held_d = 1'b1;
    else                                 held_d = held_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      rreg_q <= '0;
      rx_q   <= '0;
      cnt_q  <= '0;
      dbit_q <= 1'b0;
      act_q  <= 1'b0;
      held_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      sreg_q <= sreg_d;
      rreg_q <= rreg_d;
      rx_q   <= rx_d;
      cnt_q  <= cnt_d;
      dbit_q <= dbit_d;
      act_q  <= act_d;
      held_q <= held_d;
      done_q <= done_d;
    end
  end

  assign dbit    = dbit_q;
  assign active  = act_q;
  assign held    = held_q;
  assign rx_data = rx_q;
  assign rx_done = done_q;

  // R9: strobe lasts a single cycle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R9: received byte only moves together with the strobe
  assert_rx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(rx_q));
  // R7: a completed byte closes the frame
  assert_done_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !act_q);
endmodule

// File: rtl/serport.sv
module serport #(
  parameter int HALF_DIV = 4,
  parameter int DW       = 8,
  parameter int SYNC     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          role_slave,
  input  logic          cpol,
  input  logic          cpha,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic [DW-1:0] rx_data,
  output logic          rx_done,
  output logic          sck_out,
  input  logic          sck_in,
  input  logic          sd_in,
  output logic          sd_out,
  output logic          sd_oe,
  input  logic          ssel_n
);
  import serport_pkg::*;

  sp_evt_t m_evt, s_evt, evt;
  logic    m_busy, m_sck, s_sel_low, c_active, c_held, c_dbit;
  logic    accept, m_start;

  assign tx_ready = !m_busy && !c_active && !c_held;
  assign accept   = tx_valid && tx_ready;
  assign m_start  = accept && !role_slave;

  serport_mclk #(.HALF_DIV(HALF_DIV), .DW(DW)) u_mclk (
    .clk(clk), .rst_n(rst_n), .start(m_start), .cpol(cpol),
    .sck(m_sck), .busy(m_busy), .evt(m_evt)
  );

  serport_sync #(.SYNC(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_in(sck_in), .ssel_n(ssel_n), .cpol(cpol),
    .sel_low(s_sel_low), .evt(s_evt)
  );

  assign evt = role_slave ? s_evt : m_evt;

  serport_core #(.DW(DW)) u_core (
    .clk(clk), .rst_n(rst_n), .slave(role_slave), .cpha(cpha), .evt(evt),
    .ld(accept), .ld_data(tx_data), .sd_in(sd_in),
    .dbit(c_dbit), .active(c_active), .held(c_held),
    .rx_data(rx_data), .rx_done(rx_done)
  );

  assign sck_out = m_sck;
  assign sd_out  = c_dbit;
  assign sd_oe   = role_slave ? (!ssel_n && s_sel_low) : 1'b1;

  // R2: an accepted master byte makes the port busy
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!role_slave && accept) |=> !tx_ready);
  // R7: a detected select fall opens a slave frame
  assert_start_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (role_slave && s_evt.start) |=> c_active);
  // R8: a select held high long enough leaves no frame open
  assert_deselect_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (role_slave && $past(role_slave, 3) && ssel_n && $past(ssel_n) &&
     $past(ssel_n, 2) && $past(ssel_n, 3)) |-> !c_active);
endmodule

// File: tb/serport_bench.sv
`timescale 1ns/1ps
module serport_bench;
  localparam int HALF = 4;
  localparam int SH   = 8;

  logic clk, rst_n, role_slave, cpol, cpha, tx_valid, sck_in, sd_in_b, ssel_n, loop_en;
  logic [7:0] tx_data, rx_data, last_exp;
  logic tx_ready, rx_done, sck_out, sd_out, sd_oe, sd_in_dut;
  int errors = 0, checks = 0;
  bit finished = 0, prev_done = 0;
  logic [7:0] exp_q[$];

  assign sd_in_dut = loop_en ? sd_out : sd_in_b;

  serport #(.HALF_DIV(HALF), .DW(8), .SYNC(2)) u_serport (
    .clk(clk), .rst_n(rst_n), .role_slave(role_slave), .cpol(cpol), .cpha(cpha),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_done(rx_done), .sck_out(sck_out), .sck_in(sck_in),
    .sd_in(sd_in_dut), .sd_out(sd_out), .sd_oe(sd_oe), .ssel_n(ssel_n)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected bytes as the design reports them
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (prev_done) chk(!rx_done, "R9 done strobe one cycle", rx_done, 0);
      if (rx_done) begin
        if (exp_q.size() == 0) chk(0, "R8 unexpected rx_done", rx_data, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rx_data == e, "R7 received byte", rx_data, e);
        end
      end
      prev_done = rx_done;
    end
  end

  task automatic master_frame(input logic cp, input logic ph, input logic [7:0] d, input bit loop);
    int trans, last_t, t, bi;
    logic [7:0] cap;
    logic prev;
    bit gap_ok;
    role_slave = 0; cpol = cp; cpha = ph; loop_en = loop; sd_in_b = 1'b1;
    repeat (4) @(negedge clk);
    chk(sck_out == cp, "R2 idle clock level", sck_out, cp);
    exp_q.push_back(loop ? d : 8'hFF);
    last_exp = loop ? d : 8'hFF;
    tx_data = d; tx_valid = 1;
    @(negedge clk);
    tx_valid = 0;
    chk(!tx_ready, "R2 busy after accept", tx_ready, 0);
    if (ph) chk(sd_out == d[0], "R4 bit0 before first edge", sd_out, d[0]);
    trans = 0; last_t = 0; t = 0; bi = 0; cap = 0; prev = sck_out; gap_ok = 1;
    while (trans < 16 && t < 1000) begin
      @(negedge clk); t++;
      if (sck_out != prev) begin
        if (trans > 0 && (t - last_t) != HALF) gap_ok = 0;
        if ((prev == cp) == ph && bi < 8) begin cap[bi] = sd_out; bi++; end
        last_t = t; trans++; prev = sck_out;
      end
    end
    repeat (3 * HALF) begin
      @(negedge clk);
      if (sck_out != prev) trans++;
    end
    chk(trans == 16, "R2 sixteen clock transitions", trans, 16);
    chk(gap_ok, "R2 half period spacing", gap_ok, 1);
    chk(sck_out == cp, "R2 clock back at idle", sck_out, cp);
    chk(tx_ready, "R2 ready after frame", tx_ready, 1);
    chk(cap == d, "R3 R4 lsb-first bits at sample edges", cap, d);
    loop_en = 0;
  endtask

  task automatic slave_frame(input logic cp, input logic ph, input logic [7:0] sb,
                             input logic [7:0] mb, input int stop_at);
    role_slave = 1; cpol = cp; cpha = ph; sck_in = cp; ssel_n = 1; loop_en = 0;
    repeat (6) @(negedge clk);
    chk(!sd_oe, "R5 deselected output off", sd_oe, 0);
    tx_data = sb; tx_valid = 1;
    @(negedge clk);
    tx_valid = 0;
    chk(!tx_ready, "R10 loaded byte holds ready low", tx_ready, 0);
    if (stop_at >= 8) begin exp_q.push_back(mb); last_exp = mb; end
    ssel_n = 0;
    if (ph) sd_in_b = mb[0];
    repeat (4) @(negedge clk);
    if (ph) chk(sd_oe && sd_out == sb[0], "R6 bit0 driven on select", {sd_oe, sd_out}, {1'b1, sb[0]});
    repeat (SH - 4) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      if (i == stop_at) break;
      if (ph) begin
        chk(sd_out == sb[i], "R7 slave bit out", sd_out, sb[i]);
        sck_in = ~cp;
        repeat (SH) @(negedge clk);
        sck_in = cp;
        if (i < 7) sd_in_b = mb[i + 1];
        repeat (SH) @(negedge clk);
      end else begin
        sck_in = ~cp; sd_in_b = mb[i];
        repeat (SH) @(negedge clk);
        chk(sd_out == sb[i], "R7 slave bit out", sd_out, sb[i]);
        sck_in = cp;
        repeat (SH) @(negedge clk);
      end
    end
    repeat (SH) @(negedge clk);
    ssel_n = 1;
    repeat (6) @(negedge clk);
    chk(!sd_oe, "R5 R8 output off after deselect", sd_oe, 0);
    chk(tx_ready, "R10 ready after frame end", tx_ready, 1);
  endtask

  initial begin
    rst_n = 0; role_slave = 0; cpol = 0; cpha = 0; tx_valid = 0; tx_data = 0;
    sck_in = 0; sd_in_b = 0; ssel_n = 1; loop_en = 0; last_exp = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(tx_ready, "R1 reset ready", tx_ready, 1);
    chk(!rx_done, "R1 reset done low", rx_done, 0);
    chk(rx_data == 8'h00, "R1 reset rx byte", rx_data, 0);
    chk(sck_out == 1'b0, "R1 reset clock idle", sck_out, 0);
    chk(sd_oe, "R1 master drives data", sd_oe, 1);

    master_frame(0, 0, 8'hA5, 1);
    master_frame(0, 1, 8'h3C, 1);
    master_frame(1, 0, 8'h96, 1);
    master_frame(1, 1, 8'hE1, 1);
    master_frame(0, 1, 8'h12, 0);
    repeat (20) @(negedge clk);
    chk(rx_data == last_exp, "R9 rx byte held", rx_data, last_exp);

    slave_frame(0, 1, 8'h5B, 8'hC4, 8);
    slave_frame(0, 0, 8'h81, 8'h7E, 8);
    slave_frame(1, 1, 8'h2D, 8'hB9, 8);
    slave_frame(1, 0, 8'hF0, 8'h0F, 8);
    slave_frame(0, 1, 8'h3C, 8'h5A, 3);
    chk(rx_data == last_exp, "R8 R9 no new byte after drop", rx_data, last_exp);
    slave_frame(0, 1, 8'hC3, 8'h96, 8);
    slave_frame(1, 0, 8'h44, 8'hA1, 5);
    slave_frame(1, 0, 8'h6A, 8'h39, 8);
    repeat (20) @(negedge clk);
    chk(rx_data == last_exp, "R9 rx byte held", rx_data, last_exp);
    chk(exp_q.size() == 0, "R7 all frames completed", exp_q.size(), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule